// File: doc/BRIEF.md
# Four-Rail Power-Good Monitor with Minimum Low Time

This block turns the digital results of per-rail voltage comparators into one active-high power-good flag per rail. Each rail's comparators report two things: whether the output has climbed to the upper threshold (96 % of target) and whether it has sagged under the lower threshold (93 % of target). The monitor flags a rail as good only after it has climbed past the upper threshold. It withdraws the flag only when the output sags below the lower threshold, when the rail is switched off, or when a chip-wide fault (overvoltage, overtemperature or undervoltage) is raised. This gap between the two thresholds gives the hysteresis.

Whenever a flag drops, for any reason, that rail keeps the flag low for a fixed minimum time (50 ms in the system; `HOLD_CYCLES` clock cycles here). After that, the flag returns at the first clock edge at which the rail is enabled, no fault is present and the output sits above the upper threshold. A short fault therefore gives a low time of exactly the hold. A fault longer than the hold ends with the flag rising one edge after the fault clears. The comparator flags are asynchronous to the clock and pass through a two-stage synchroniser before they are used. The enable and fault inputs are taken to be synchronous already.

Top module: `pg_monitor`

## Requirements
- R1: While reset is asserted every bit of `pg` is 0. Every hold counter starts at zero, so after reset a rail may rise without first serving a hold time.
- R2: A rail whose flag is low rises three clock edges after `above_rise[i]` goes to 1. The rise needs `rail_en[i]`=1, `fault`=0, `below_fall[i]`=0 and an expired hold. With `above_rise[i]` and `below_fall[i]` both 1, the flag stays low.
- R3: Hysteresis. With the flag high and both comparator bits 0 (the band between the thresholds), the flag stays high. With the flag low and both bits 0, the flag stays low even after the hold has expired.
- R4: A high flag drops three clock edges after `below_fall[i]` goes to 1.
- R5: Setting `rail_en[i]` to 0 drops `pg[i]` at the next clock edge.
- R6: Setting `fault` to 1 drops all four `pg` bits at the next clock edge.
- R7: After any drop, `pg[i]` stays low for at least `HOLD_CYCLES` cycles. If every rise condition holds throughout, it is low for exactly `HOLD_CYCLES` cycles.
- R8: If a fault clears before the hold expires, the flag rises when the hold expires. If the fault outlasts the hold, the flag rises at the first edge after the fault clears.
- R9: Each rail keeps its own hold counter, which restarts on every new drop of that rail's flag. A drop on one rail does not affect the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_en | input | NUM_RAILS | Per-rail enable, 1 = rail on |
| fault | input | 1 | Chip-wide fault, 1 = fault active |
| above_rise | input | NUM_RAILS | Asynchronous comparator: 1 = output at or above the upper threshold |
| below_fall | input | NUM_RAILS | Asynchronous comparator: 1 = output below the lower threshold |
| pg | output | NUM_RAILS | Per-rail power-good, 1 = good |

## Verification
The hardest case to reach is a rail whose hold has expired but whose output is in the band between the thresholds. A drop must first be forced through the lower threshold, and both comparator bits must then be left at 0 for longer than the hold. The bench reaches it this way on rail 0 and then shows that only a later upper-threshold crossing raises the flag. Fault durations either side of the hold are also driven. This shows both release paths, one where the end of the hold decides and one where the end of the fault decides.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;

    // Phase of one rail's power-good tracker.
    typedef enum logic [1:0] {
        PH_READY = 2'd0,   // flag low, no hold pending
        PH_HOLD  = 2'd1,   // flag low, minimum low time running
        PH_GOOD  = 2'd2    // flag high
    } rail_phase_e;

    // Counter width needed to hold values 0 .. n-1.
    function automatic int hold_cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pg_rail.sv
module pg_rail
    import pg_mon_pkg::*;
#(
    parameter int HOLD_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fault_i,
    input  logic above_i,
    input  logic below_i,
    output logic pg_o
);

    localparam int CW = hold_cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        rail_phase_e     phase;
        logic [CW-1:0]   cnt;
    } rail_state_t;

    rail_state_t st_d, st_q;
    logic        drop_req;
    logic        rise_ok;

    always_comb begin
        st_d     = st_q;
        drop_req = !en_i || fault_i || below_i;
        rise_ok  = en_i && !fault_i && above_i && !below_i;
        unique case (st_q.phase)
            PH_GOOD: begin
                if (drop_req) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = HOLD_LOAD;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (rise_ok) begin
                    st_d.phase = PH_GOOD;
                end else begin
                    st_d.phase = PH_READY;
                end
            end
            PH_READY: begin
                if (rise_ok) begin
                    st_d.phase = PH_GOOD;
                end
            end
            default: begin
                st_d.phase = PH_READY;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_READY;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pg_o = (st_q.phase == PH_GOOD);

    // R5: a disabled rail is low after the next edge
    a_r5_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pg_o);

    // R4: a sagging output drops a high flag
    a_r4_below_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_o && below_i) |=> !pg_o);

    // R2: a rise needs every condition on the previous edge
    a_r2_rise_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_o) |-> $past(en_i && !fault_i && above_i && !below_i));

    // R7: a rise happens only once the hold count is exhausted
    a_r7_rise_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_o) |-> ($past(st_q.cnt) == '0));

    // R3: in the band between thresholds a high flag stays high
    a_r3_band_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_o && en_i && !fault_i && !below_i) |=> pg_o);

    // R9: the hold count never leaves its range
    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= HOLD_LOAD);

endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
    parameter int NUM_RAILS   = 4,
    parameter int HOLD_CYCLES = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_en,
    input  logic                 fault,
    input  logic [NUM_RAILS-1:0] above_rise,
    input  logic [NUM_RAILS-1:0] below_fall,
    output logic [NUM_RAILS-1:0] pg
);

    localparam int SW = 2 * NUM_RAILS;

    logic [SW-1:0]        cmp_async;
    logic [SW-1:0]        cmp_sync;
    logic [NUM_RAILS-1:0] above_s;
    logic [NUM_RAILS-1:0] below_s;

    assign cmp_async = {below_fall, above_rise};

    pg_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_async),
        .sync_o  (cmp_sync)
    );

    assign above_s = cmp_sync[NUM_RAILS-1:0];
    assign below_s = cmp_sync[SW-1:NUM_RAILS];

    generate
        for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
            pg_rail #(
                .HOLD_CYCLES (HOLD_CYCLES)
            ) u_rail (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (rail_en[r]),
                .fault_i (fault),
                .above_i (above_s[r]),
                .below_i (below_s[r]),
                .pg_o    (pg[r])
            );
        end
    endgenerate

    // R6: a chip-wide fault clears every flag on the next edge
    a_r6_fault_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (pg == '0));

    // R1: outputs are low while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_low: assert (pg == '0);
        end
    end

endmodule

// File: tb/pg_monitor_bench.sv
module pg_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 4;
    localparam int H          = 20;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_en = '0;
    logic          fault = 1'b0;
    logic [NR-1:0] above_rise = '0;
    logic [NR-1:0] below_fall = '0;
    logic [NR-1:0] pg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_monitor #(
        .NUM_RAILS   (NR),
        .HOLD_CYCLES (H),
        .SYNC_STAGES (2)
    ) u_pg_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_en    (rail_en),
        .fault      (fault),
        .above_rise (above_rise),
        .below_fall (below_fall),
        .pg         (pg)
    );

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check(input logic [31:0] got, input logic [31:0] exp,
                         input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // counts consecutive low samples of pg[i], starting at the current sample
    task automatic measure_low(input int i, output int lows);
        lows = 0;
        while (pg[i] === 1'b0 && lows < 1000) begin
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic wait_all_good();
        for (int k = 0; k < H + 10 && pg !== 4'hF; k++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int lows;
        // R1: reset state with everything asking to be good
        rail_en    = 4'hF;
        above_rise = 4'hF;
        step(5);
        check(pg, 4'h0, "R1", "pg during reset");
        rst_n = 1'b1;
        step(2);
        check(pg, 4'h0, "R2", "pg before sync latency");
        step(1);
        check(pg, 4'hF, "R1", "pg rises without hold after reset");

        // sweep of rails and drop causes: R4, R5, R6, R7, R9
        for (int i = 0; i < NR; i++) begin
            for (int cause = 0; cause < 3; cause++) begin
                wait_all_good();
                check(pg, 4'hF, "R2", "all good before drop");
                if (cause == 0) begin
                    above_rise[i] = 1'b0;
                    below_fall[i] = 1'b1;
                    step(2);
                    check(pg[i], 1'b1, "R4", "flag before below latency");
                    step(1);
                    check(pg[i], 1'b0, "R4", "flag after below latency");
                    check(pg & ~(4'h1 << i), 4'hF & ~(4'h1 << i), "R9", "other rails on below");
                    above_rise[i] = 1'b1;
                    below_fall[i] = 1'b0;
                end else if (cause == 1) begin
                    rail_en[i] = 1'b0;
                    step(1);
                    check(pg[i], 1'b0, "R5", "flag after disable");
                    check(pg & ~(4'h1 << i), 4'hF & ~(4'h1 << i), "R9", "other rails on disable");
                    rail_en[i] = 1'b1;
                end else begin
                    fault = 1'b1;
                    step(1);
                    check(pg, 4'h0, "R6", "all flags after fault");
                    fault = 1'b0;
                end
                measure_low(i, lows);
                check(lows, H, "R7", $sformatf("low time rail %0d cause %0d", i, cause));
            end
        end

        // R8: short fault, release decided by the hold
        wait_all_good();
        fault = 1'b1;
        step(1);
        fault = 1'b0;
        step(4);
        check(pg, 4'h0, "R8", "flags low after short fault");
        measure_low(2, lows);
        check(lows, H - 4, "R8", "remaining hold after short fault");
        check(pg, 4'hF, "R8", "all rails back after short fault");

        // R8: long fault, release decided by fault end
        fault = 1'b1;
        step(H + 10);
        check(pg, 4'h0, "R8", "flags low during long fault");
        fault = 1'b0;
        step(1);
        check(pg, 4'hF, "R8", "rise one edge after long fault clears");

        // R3: hysteresis on rail 0
        above_rise[0] = 1'b0;
        step(6);
        check(pg[0], 1'b1, "R3", "high flag kept in band");
        below_fall[0] = 1'b1;
        step(3);
        check(pg[0], 1'b0, "R4", "drop after entering below");
        below_fall[0] = 1'b0;
        step(H + 5);
        check(pg[0], 1'b0, "R3", "low flag kept in band after hold");
        above_rise[0] = 1'b1;
        below_fall[0] = 1'b1;
        step(5);
        check(pg[0], 1'b0, "R2", "no rise with both comparator bits set");
        below_fall[0] = 1'b0;
        step(2);
        check(pg[0], 1'b0, "R2", "no rise before sync latency");
        step(1);
        check(pg[0], 1'b1, "R2", "rise after sync latency");

        // R9: back-to-back drops restart the hold each time
        for (int rep = 0; rep < 3; rep++) begin
            rail_en[3] = 1'b0;
            step(1);
            rail_en[3] = 1'b1;
            measure_low(3, lows);
            check(lows, H, "R9", $sformatf("restarted hold pass %0d", rep));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule